// File: doc/BRIEF.md
# Descriptor Ring DMA Walker

This block is a single-channel copy engine driven by a ring of buffer descriptors held in memory. A two-word channel block at a fixed address holds the descriptor pointer to resume from and the ring base. A start pulse makes the engine load both pointers and fetch the three-word descriptor at the current pointer. Each descriptor holds a count and command word, a source address and a destination address. If the engine owns the descriptor, it copies the bytes through its single memory port. It then returns the descriptor to software with an updated status byte, may pulse an interrupt, and stores the next pointer in the channel block.

Software arms a descriptor by setting its ownership bit. The wrap and continue bits decide whether the walk moves on to the next entry, jumps back to the base, or stops. When the engine stops, it leaves the pointer it stored in the channel block, so the next start resumes from there. All memory traffic uses one request/grant port, and every access is a full 32-bit word address with byte enables.

Top module: `bd_ring_walker`

## Requirements
- R1: After reset the engine is idle (`idle_o` high), makes no memory request and holds `irq_o` low.
- R2: A start pulse while idle makes the engine read the resume pointer at `CB_ADDR` and the ring base at `CB_ADDR+4`. It then reads the descriptor words at the resume pointer, +4 and +8. A start pulse while busy is ignored.
- R3: Descriptor word 0 carries the byte count in bits 15:0, status in bits 23:16 and command in bits 31:24. Status bit 0 (0x01) marks engine ownership. If that bit is clear, the engine returns to idle and writes nothing.
- R4: An owned descriptor copies `count` bytes from the address in word 1 to the address in word 2. Command 0 selects 4-byte beats, 1 selects 1-byte beats and 2 selects 2-byte beats. Each beat reads the source word, moves the unit to the destination byte lanes and writes only those lanes.
- R5: After the copy, word 0 is rewritten with the count and command unchanged, the ownership bit cleared and the other status bits kept.
- R6: The descriptor is written back with status bit 4 (0x10) set, and no further data is written, when any of these holds: the command is above 2, an address is not aligned to the beat width, the count is not a multiple of the width, or `mem_err_i` accompanies a data beat.
- R7: If status bit 3 (0x08) is set, `irq_o` is high for exactly one cycle, in the cycle after the status write-back is granted.
- R8: After each processed descriptor, the next pointer is written to `CB_ADDR`. The next pointer is the ring base if status bit 1 (0x02) is set, and the current pointer + 12 otherwise.
- R9: After the pointer write, status bit 2 (0x04) set fetches the next descriptor. If that bit is clear, the engine goes idle.
- R10: A request that is not granted keeps its address, direction and write data unchanged until the grant.
- R11: A count of zero makes no data access; the status write-back and pointer update still happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| idle_o | output | 1 | Engine is idle |
| irq_o | output | 1 | One-cycle completion interrupt |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Write byte enables |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rdata_i | input | 32 | Read data, valid in the grant cycle |
| mem_err_i | input | 1 | Error response, valid in the grant cycle |

## Verification
The bench builds the engine with `AW=12` and `CB_ADDR=0`, so a 4 KiB word memory model covers the channel block, a three-entry ring, source buffers and destination buffers. With that space, one run can walk a full ring through a wrap back to a descriptor that is no longer owned. A switchable grant pattern stalls two of every three requests, which tests request holding under back-pressure. An address-matched error response is injected partway through a multi-beat copy.

// File: rtl/bdw_pkg.sv
package bdw_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned CNT_W      = 16;
  localparam int unsigned DESC_BYTES = 12;
  // status bit positions inside the status byte
  localparam int unsigned ST_OWN  = 0;
  localparam int unsigned ST_WRAP = 1;
  localparam int unsigned ST_CONT = 2;
  localparam int unsigned ST_INTR = 3;
  localparam int unsigned ST_ERR  = 4;
  localparam int unsigned ST_LSB  = 16;
  localparam int unsigned CMD_LSB = 24;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CUR, S_RD_BASE, S_RD_W0, S_RD_W1, S_RD_W2,
    S_CHK, S_XR, S_XW, S_WB, S_PTR
  } walk_state_e;
endpackage

// File: rtl/bdw_check.sv
module bdw_check (
  input  logic [7:0] cmd_i,
  input  logic [1:0] cnt_lo_i,
  input  logic [1:0] src_lo_i,
  input  logic [1:0] dst_lo_i,
  output logic [2:0] step_o,
  output logic       bad_o
);
  logic bad_cmd;
  always_comb begin
    bad_cmd = 1'b0;
    unique case (cmd_i)
      8'd0:    step_o = 3'd4;
      8'd1:    step_o = 3'd1;
      8'd2:    step_o = 3'd2;
      default: begin step_o = 3'd4; bad_cmd = 1'b1; end
    endcase
    unique case (step_o)
      3'd4:    bad_o = bad_cmd | (|src_lo_i) | (|dst_lo_i) | (|cnt_lo_i);
      3'd2:    bad_o = bad_cmd | src_lo_i[0] | dst_lo_i[0] | cnt_lo_i[0];
      default: bad_o = bad_cmd;
    endcase
  end
endmodule

// File: rtl/bdw_lane.sv
module bdw_lane (
  input  logic [31:0] rdata_i,
  input  logic [1:0]  src_lo_i,
  input  logic [1:0]  dst_lo_i,
  input  logic [2:0]  step_i,
  input  logic [31:0] unit_i,
  output logic [31:0] unit_o,
  output logic [31:0] wdata_o,
  output logic [3:0]  be_o
);
  logic [3:0] mask;
  always_comb begin
    unit_o  = rdata_i >> {src_lo_i, 3'b000};
    wdata_o = unit_i << {dst_lo_i, 3'b000};
    unique case (step_i)
      3'd1:    mask = 4'b0001;
      3'd2:    mask = 4'b0011;
      default: mask = 4'b1111;
    endcase
    be_o = mask << dst_lo_i;
  end
endmodule

// File: rtl/bdw_next.sv
module bdw_next #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] base_i,
  input  logic          wrap_i,
  output logic [AW-1:0] next_o
);
  localparam logic [AW-1:0] STRIDE = AW'(bdw_pkg::DESC_BYTES);
  assign next_o = wrap_i ? base_i : cur_i + STRIDE;
endmodule

// File: rtl/bd_ring_walker.sv
module bd_ring_walker #(
  parameter int unsigned AW      = 16,
  parameter int unsigned CB_ADDR = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          idle_o,
  output logic          irq_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  output logic [3:0]    mem_be_o,
  input  logic          mem_gnt_i,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_err_i
);
  import bdw_pkg::*;

  localparam logic [AW-1:0] CB_CUR  = AW'(CB_ADDR);
  localparam logic [AW-1:0] CB_BASE = AW'(CB_ADDR + 4);

  walk_state_e  state_q;
  logic [AW-1:0] cur_q, base_q, src_q, dst_q, next_ptr;
  logic [31:0]  w0_q, unit_q, unit_rd, lane_wdata;
  logic [CNT_W-1:0] rem_q;
  logic         err_q, irq_q, bad, fire;
  logic [2:0]   step;
  logic [3:0]   lane_be;
  logic [7:0]   status_q, status_wb;
  logic [CNT_W-1:0] step_cnt;

  assign status_q  = w0_q[ST_LSB +: 8];
  assign status_wb = (status_q & ~(8'(1) << ST_OWN)) | (err_q ? (8'(1) << ST_ERR) : 8'h00);
  assign step_cnt  = CNT_W'(step);
  assign fire      = mem_req_o & mem_gnt_i;

  bdw_check u_check (
    .cmd_i    (w0_q[CMD_LSB +: 8]),
    .cnt_lo_i (w0_q[1:0]),
    .src_lo_i (src_q[1:0]),
    .dst_lo_i (dst_q[1:0]),
    .step_o   (step),
    .bad_o    (bad)
  );

  bdw_lane u_lane (
    .rdata_i  (mem_rdata_i),
    .src_lo_i (src_q[1:0]),
    .dst_lo_i (dst_q[1:0]),
    .step_i   (step),
    .unit_i   (unit_q),
    .unit_o   (unit_rd),
    .wdata_o  (lane_wdata),
    .be_o     (lane_be)
  );

  bdw_next #(.AW(AW)) u_next (
    .cur_i  (cur_q),
    .base_i (base_q),
    .wrap_i (status_q[ST_WRAP]),
    .next_o (next_ptr)
  );

  // memory port drive, decoded from state only
  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_q;
    mem_wdata_o = '0;
    mem_be_o    = 4'b1111;
    unique case (state_q)
      S_RD_CUR:  mem_addr_o = CB_CUR;
      S_RD_BASE: mem_addr_o = CB_BASE;
      S_RD_W0:   mem_addr_o = cur_q;
      S_RD_W1:   mem_addr_o = cur_q + AW'(4);
      S_RD_W2:   mem_addr_o = cur_q + AW'(8);
      S_XR:      mem_addr_o = {src_q[AW-1:2], 2'b00};
      S_XW: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = {dst_q[AW-1:2], 2'b00};
        mem_wdata_o = lane_wdata;
        mem_be_o    = lane_be;
      end
      S_WB: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = {w0_q[31:24], status_wb, w0_q[15:0]};
      end
      S_PTR: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = CB_CUR;
        mem_wdata_o = 32'(next_ptr);
      end
      default: mem_req_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      base_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      w0_q    <= '0;
      unit_q  <= '0;
      rem_q   <= '0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) state_q <= S_RD_CUR;
        S_RD_CUR: if (fire) begin
          cur_q   <= mem_rdata_i[AW-1:0];
          state_q <= S_RD_BASE;
        end
        S_RD_BASE: if (fire) begin
          base_q  <= mem_rdata_i[AW-1:0];
          state_q <= S_RD_W0;
        end
        S_RD_W0: if (fire) begin
          w0_q    <= mem_rdata_i;
          err_q   <= 1'b0;
          state_q <= mem_rdata_i[ST_LSB + ST_OWN] ? S_RD_W1 : S_IDLE;
        end
        S_RD_W1: if (fire) begin
          src_q   <= mem_rdata_i[AW-1:0];
          state_q <= S_RD_W2;
        end
        S_RD_W2: if (fire) begin
          dst_q   <= mem_rdata_i[AW-1:0];
          state_q <= S_CHK;
        end
        S_CHK: begin
          rem_q <= w0_q[CNT_W-1:0];
          if (bad) begin
            err_q   <= 1'b1;
            state_q <= S_WB;
          end else if (w0_q[CNT_W-1:0] == '0) begin
            state_q <= S_WB;
          end else begin
            state_q <= S_XR;
          end
        end
        S_XR: if (fire) begin
          if (mem_err_i) begin
            err_q   <= 1'b1;
            state_q <= S_WB;
          end else begin
            unit_q  <= unit_rd;
            state_q <= S_XW;
          end
        end
        S_XW: if (fire) begin
          if (mem_err_i) begin
            err_q   <= 1'b1;
            state_q <= S_WB;
          end else begin
            src_q   <= src_q + AW'(step);
            dst_q   <= dst_q + AW'(step);
            rem_q   <= rem_q - step_cnt;
            state_q <= (rem_q == step_cnt) ? S_WB : S_XR;
          end
        end
        S_WB: if (fire) begin
          irq_q   <= status_q[ST_INTR];
          state_q <= S_PTR;
        end
        S_PTR: if (fire) begin
          cur_q   <= next_ptr;
          state_q <= status_q[ST_CONT] ? S_RD_W0 : S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign idle_o = (state_q == S_IDLE);
  assign irq_o  = irq_q;
endmodule

// File: rtl/bdw_chk.sv
module bdw_chk #(
  parameter int unsigned AW      = 16,
  parameter int unsigned CB_ADDR = 0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          idle_o,
  input logic          irq_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic [3:0]    mem_be_o,
  input logic          mem_gnt_i
);
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));
  // R4
  be_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> ($countones(mem_be_o) == 1 ||
                               $countones(mem_be_o) == 2 ||
                               $countones(mem_be_o) == 4));
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mem_req_o);
  // R2
  start_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && idle_o |=> mem_req_o && !mem_we_o && mem_addr_o == AW'(CB_ADDR));
  // R7
  irq_after_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mem_req_o && mem_gnt_i && mem_we_o));
  // R7
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

bind bd_ring_walker bdw_chk #(.AW(AW), .CB_ADDR(CB_ADDR)) u_bdw_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .idle_o      (idle_o),
  .irq_o       (irq_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_be_o    (mem_be_o),
  .mem_gnt_i   (mem_gnt_i)
);

// File: tb/tb_bd_ring_walker.sv
`timescale 1ns/1ps
module tb_bd_ring_walker;
  localparam int unsigned AW = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic idle, irq, req, we, gnt = 1'b0, err;
  logic [AW-1:0] addr;
  logic [31:0] wdata, rdata;
  logic [3:0] be;
  logic [31:0] mem [0:1023];
  logic stall = 1'b0, err_en = 1'b0;
  logic [AW-1:0] err_addr = '0;
  int n_chk = 0, n_fail = 0, irq_cnt = 0, dwr_cnt = 0, cyc = 0;

  always #2 clk = ~clk;

  bd_ring_walker #(.AW(AW), .CB_ADDR(0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .idle_o(idle), .irq_o(irq),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_be_o(be), .mem_gnt_i(gnt), .mem_rdata_i(rdata), .mem_err_i(err));

  assign rdata = mem[addr[11:2]];
  assign err   = req & gnt & err_en & (addr == err_addr);

  always @(posedge clk) begin
    if (req && gnt && we && !err) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) mem[addr[11:2]][8*b +: 8] <= wdata[8*b +: 8];
      if (addr >= 12'h800) dwr_cnt <= dwr_cnt + 1;
    end
  end

  always @(negedge clk) begin
    cyc++;
    gnt = !stall || (cyc % 3 == 0);
    if (irq) irq_cnt++;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req_s, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
  endtask
  function automatic logic [31:0] w0(input logic [7:0] cmd, input logic [7:0] st, input logic [15:0] cnt);
    return {cmd, st, cnt};
  endfunction
  task automatic put_desc(input int a, input logic [31:0] d0, input int src, input int dst);
    mem[a/4] = d0; mem[a/4+1] = 32'(src); mem[a/4+2] = 32'(dst);
  endtask
  task automatic put_cb(input int cur, input int base);
    mem[0] = 32'(cur); mem[1] = 32'(base);
  endtask

  task automatic run(input int busy_at);
    int n = 0;
    irq_cnt = 0; dwr_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!idle && n < 5000) begin
      @(negedge clk); n++;
      if (n == busy_at) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 engine idle at end", 32'(idle), 32'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 idle after reset", 32'(idle), 32'd1);
    chk("R1 no request after reset", 32'(req), 32'd0);
    chk("R1 irq low after reset", 32'(irq), 32'd0);
  endtask

  task automatic t_single(input logic stall_on);
    clear_mem(); stall = stall_on;
    put_cb(12'h100, 12'h100);
    put_desc(12'h100, w0(8'd0, 8'h09, 16'd8), 12'h400, 12'h800);
    mem[12'h100] = 32'hA5A5_0001; mem[12'h101] = 32'h5A5A_0002;
    run(0);
    chk("R4 word copy beat 0", mem[12'h200], 32'hA5A5_0001);
    chk("R4 word copy beat 1", mem[12'h201], 32'h5A5A_0002);
    chk("R4 no write past count", mem[12'h202], 32'h0);
    chk("R5 status written back", mem[12'h040], w0(8'd0, 8'h08, 16'd8));
    chk("R8 pointer advanced by 12", mem[0], 32'h10C);
    chk("R7 one interrupt", 32'(irq_cnt), 32'd1);
    stall = 1'b0;
  endtask

  task automatic t_ring();
    clear_mem();
    put_cb(12'h100, 12'h100);
    put_desc(12'h100, w0(8'd1, 8'h0D, 16'd3), 12'h401, 12'h802);
    put_desc(12'h10C, w0(8'd2, 8'h05, 16'd4), 12'h410, 12'h822);
    put_desc(12'h118, w0(8'd0, 8'h0F, 16'd4), 12'h420, 12'h840);
    mem[12'h100] = 32'h4433_2211;
    mem[12'h104] = 32'h8877_6655;
    mem[12'h108] = 32'hCAFE_F00D;
    run(0);
    chk("R4 byte lanes low word", mem[12'h200], 32'h3322_0000);
    chk("R4 byte lanes next word", mem[12'h201], 32'h0000_0044);
    chk("R4 half lanes upper", mem[12'h208], 32'h6655_0000);
    chk("R4 half lanes lower", mem[12'h209], 32'h0000_8877);
    chk("R4 word after wrap entry", mem[12'h210], 32'hCAFE_F00D);
    chk("R5 entry0 status", mem[12'h040], w0(8'd1, 8'h0C, 16'd3));
    chk("R5 entry1 status", mem[12'h043], w0(8'd2, 8'h04, 16'd4));
    chk("R5 entry2 status", mem[12'h046], w0(8'd0, 8'h0E, 16'd4));
    chk("R8 wrap reloads base", mem[0], 32'h100);
    chk("R7 interrupts only for flagged entries", 32'(irq_cnt), 32'd2);
    chk("R3 stop at returned entry, no extra writes", 32'(dwr_cnt), 32'd6);
  endtask

  task automatic t_not_owned();
    clear_mem();
    put_cb(12'h100, 12'h100);
    put_desc(12'h100, w0(8'd0, 8'h0C, 16'd4), 12'h400, 12'h800);
    mem[12'h100] = 32'h1234_5678;
    run(0);
    chk("R3 destination untouched", mem[12'h200], 32'h0);
    chk("R3 descriptor untouched", mem[12'h040], w0(8'd0, 8'h0C, 16'd4));
    chk("R3 pointer untouched", mem[0], 32'h100);
    chk("R3 no interrupt", 32'(irq_cnt), 32'd0);
  endtask

  task automatic t_errors();
    clear_mem();
    put_cb(12'h100, 12'h100);
    put_desc(12'h100, w0(8'd3, 8'h0D, 16'd4), 12'h400, 12'h800);
    put_desc(12'h10C, w0(8'd0, 8'h05, 16'd3), 12'h400, 12'h800);
    put_desc(12'h118, w0(8'd2, 8'h05, 16'd4), 12'h401, 12'h800);
    put_desc(12'h124, w0(8'd0, 8'h01, 16'd8), 12'h430, 12'h860);
    mem[12'h100] = 32'hDEAD_BEEF;
    mem[12'h10C] = 32'h1111_1111; mem[12'h10D] = 32'h2222_2222;
    err_en = 1'b1; err_addr = 12'h434;
    run(0);
    err_en = 1'b0;
    chk("R6 bad command flagged", mem[12'h040], w0(8'd3, 8'h1C, 16'd4));
    chk("R6 odd count flagged", mem[12'h043], w0(8'd0, 8'h14, 16'd3));
    chk("R6 misaligned source flagged", mem[12'h046], w0(8'd2, 8'h14, 16'd4));
    chk("R6 bus error flagged", mem[12'h049], w0(8'd0, 8'h10, 16'd8));
    chk("R6 beat before error kept", mem[12'h218], 32'h1111_1111);
    chk("R6 no write after error", mem[12'h219], 32'h0);
    chk("R6 rejected entries write no data", mem[12'h200], 32'h0);
    chk("R6 single data write in total", 32'(dwr_cnt), 32'd1);
    chk("R8 pointer after four entries", mem[0], 32'h130);
    chk("R7 interrupt count with errors", 32'(irq_cnt), 32'd1);
  endtask

  task automatic t_zero();
    clear_mem();
    put_cb(12'h100, 12'h100);
    put_desc(12'h100, w0(8'd0, 8'h09, 16'd0), 12'h400, 12'h800);
    mem[12'h100] = 32'hFFFF_FFFF;
    run(0);
    chk("R11 no data writes", 32'(dwr_cnt), 32'd0);
    chk("R11 status still returned", mem[12'h040], w0(8'd0, 8'h08, 16'd0));
    chk("R11 pointer still advanced", mem[0], 32'h10C);
    chk("R11 interrupt still raised", 32'(irq_cnt), 32'd1);
  endtask

  task automatic t_busy_start();
    clear_mem();
    put_cb(12'h100, 12'h100);
    put_desc(12'h100, w0(8'd0, 8'h09, 16'd16), 12'h400, 12'h800);
    put_desc(12'h10C, w0(8'd0, 8'h09, 16'd4), 12'h400, 12'h900);
    run(6);
    chk("R2 busy start ignored: one interrupt", 32'(irq_cnt), 32'd1);
    chk("R2 busy start ignored: next entry still armed", mem[12'h043], w0(8'd0, 8'h09, 16'd4));
    chk("R2 busy start ignored: pointer", mem[0], 32'h10C);
    chk("R2 busy start ignored: data writes", 32'(dwr_cnt), 32'd4);
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single(1'b0);
    t_single(1'b1);   // R10 under grant stalls
    t_ring();
    t_not_owned();
    t_errors();
    t_zero();
    t_busy_start();
    summary();
    $finish;
  end
endmodule